// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that retires exactly one instruction on every clock edge. Within one cycle it fetches the word addressed by the program counter, decodes it with hardwired combinational control, reads two source registers, runs the ALU, and accesses data memory. At the next rising edge it commits the register result, the memory store and the new program counter together. The core holds its own instruction memory, data memory, and a 32-entry register file. All three are modelled as plain arrays. The environment fills the instruction memory before it releases reset.

The core supports these operations: register-register add, subtract, and, or, xor, nor and signed set-less-than; add-immediate; word load and store; branch on equal and branch on not-equal; and an absolute jump within the current 256 MB region. Each cycle the core drives a commit view of its outputs, so that the results can be seen without probing its internals. This view gives the current program counter, the register write that is about to happen, and the memory store that is about to happen.

Top module: `sc_core`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high at a rising edge, the PC becomes 0 at that edge. While `rst` is high, `rf_we_o` and `dm_we_o` stay low, so no register or memory is written.
- R2: Each rising edge out of reset retires one instruction. For every instruction that is not a taken branch or a jump, the next PC is PC + 4.
- R3: Opcode 0 (bits 31:26) is register-register. The destination is bits 15:11 and the sources are bits 25:21 and 20:16. The funct field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor, 0x2A signed set-less-than (result 1 or 0).
- R4: Opcode 0x08 writes register[bits 20:16] with register[bits 25:21] plus the sign-extended immediate in bits 15:0.
- R5: Register 0 reads as zero. An instruction that names register 0 as its destination writes nothing, and `rf_we_o` stays low.
- R6: Opcode 0x2B stores register[20:16] at the byte address register[25:21] + sign-extended bits 15:0, and makes no register write. Opcode 0x23 loads the word at the same kind of address into register[20:16]. The word index is address bits 9:2.
- R7: Opcode 0x04 (equal) and opcode 0x05 (not equal) compare register[25:21] with register[20:16]. When the condition holds, the next PC is PC + 4 + (sign-extended bits 15:0 shifted left by 2). Otherwise the next PC is PC + 4. Neither opcode writes anything.
- R8: Opcode 0x02 sets the next PC to {(PC+4)[31:28], bits 25:0, 2'b00} and writes nothing.
- R9: An unsupported opcode, or opcode 0 with an unsupported funct, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | A register write commits at the coming edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | A data-memory store commits at the coming edge |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data |

## Verification
The checker assumes that the instruction memory is filled before reset is released, and that every word the core fetches is defined. The checker also assumes that load and store addresses are word aligned, and that every register is written before it is read. The stimulus program respects all of these assumptions. It fills every instruction word with a harmless filler before it writes the program itself. It computes every address from a known base so that the address ends on a four-byte boundary. It writes every register it reads before it reads it. It reads only data-memory words that it has already stored.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

   localparam int XLEN = 32;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_J     = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_BNE   = 6'h05;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_XOR = 6'h26;
   localparam logic [5:0] FN_NOR = 6'h27;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic    dst_is_rd;   // destination from bits 15:11
      logic    b_is_imm;    // second operand from immediate
      logic    reg_we;
      logic    load_sel;    // write-back from memory
      logic    mem_re;
      logic    mem_we;
      logic    branch;
      logic    branch_ne;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl        = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (opcode)
         OP_RTYPE: begin
            ctrl.dst_is_rd = 1'b1;
            ctrl.reg_we    = 1'b1;
            case (funct)
               FN_ADD:  ctrl.alu_op = ALU_ADD;
               FN_SUB:  ctrl.alu_op = ALU_SUB;
               FN_AND:  ctrl.alu_op = ALU_AND;
               FN_OR:   ctrl.alu_op = ALU_OR;
               FN_XOR:  ctrl.alu_op = ALU_XOR;
               FN_NOR:  ctrl.alu_op = ALU_NOR;
               FN_SLT:  ctrl.alu_op = ALU_SLT;
               default: ctrl.reg_we = 1'b0;
            endcase
         end
         OP_ADDI: begin
            ctrl.b_is_imm = 1'b1;
            ctrl.reg_we   = 1'b1;
         end
         OP_LW: begin
            ctrl.b_is_imm = 1'b1;
            ctrl.reg_we   = 1'b1;
            ctrl.load_sel = 1'b1;
            ctrl.mem_re   = 1'b1;
         end
         OP_SW: begin
            ctrl.b_is_imm = 1'b1;
            ctrl.mem_we   = 1'b1;
         end
         OP_BEQ: begin
            ctrl.branch = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         OP_BNE: begin
            ctrl.branch    = 1'b1;
            ctrl.branch_ne = 1'b1;
            ctrl.alu_op    = ALU_SUB;
         end
         OP_J: begin
            ctrl.jump = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
   import sc_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y,
   output logic             zero
);

   if (WIDTH < 2) begin : g_bad_width
      $error("sc_alu: WIDTH must be at least 2");
   end

   always_comb begin
      unique case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_XOR: y = a ^ b;
         ALU_NOR: y = ~(a | b);
         ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
   parameter  int NREG  = 32,
   parameter  int WIDTH = 32,
   parameter  int NRD   = 2,
   localparam int AW    = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr [NRD],
   output logic [WIDTH-1:0] rdata [NRD]
);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("sc_regfile: NREG must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] regs [NREG];

   // Entry 0 is never written; its reads are forced to zero.
   always_ff @(posedge clk) begin
      if (we && waddr != '0) regs[waddr] <= wdata;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
   end

endmodule

// File: rtl/sc_wordmem.sv
`timescale 1ns/1ps
module sc_wordmem #(
   parameter  int DEPTH    = 256,
   parameter  int WIDTH    = 32,
   parameter  bit WRITABLE = 1'b1,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             re,
   input  logic             we,
   input  logic [AW-1:0]    idx,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sc_wordmem: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] cells [DEPTH];

   assign rdata = re ? cells[idx] : '0;

   if (WRITABLE) begin : g_wr
      always_ff @(posedge clk) begin
         if (we) cells[idx] <= wdata;
      end
   end else begin : g_ro
      logic unused_wr;
      assign unused_wr = we ^ (^wdata) ^ clk;
   end

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
   import sc_pkg::*;
#(
   parameter int          IMEM_DEPTH = 256,
   parameter int          DMEM_DEPTH = 256,
   parameter int          NREG       = 32,
   parameter logic [31:0] RESET_PC   = 32'h0
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] pc_o,
   output logic        rf_we_o,
   output logic [4:0]  rf_waddr_o,
   output logic [31:0] rf_wdata_o,
   output logic        dm_we_o,
   output logic [31:0] dm_addr_o,
   output logic [31:0] dm_wdata_o
);

   localparam int IAW = $clog2(IMEM_DEPTH);
   localparam int DAW = $clog2(DMEM_DEPTH);
   localparam int RAW = $clog2(NREG);

   if (NREG != 32) begin : g_bad_nreg
      $error("sc_core: the instruction format fixes NREG at 32");
   end
   if (IAW > 30 || DAW > 30) begin : g_bad_depth
      $error("sc_core: memory depth exceeds the address space");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
      $error("sc_core: RESET_PC must be word aligned");
   end

   logic [XLEN-1:0] pc, pc_plus4, br_target, jmp_target, next_pc;
   logic [XLEN-1:0] inst, imm_sx, alu_b, alu_y, load_data, wb_data;
   logic [XLEN-1:0] rd_data [2];
   logic [RAW-1:0]  rd_addr [2];
   logic [RAW-1:0]  waddr;
   logic            alu_zero, taken, reg_we_eff, mem_we_eff;
   ctrl_t           ctrl;
   logic            unused_shamt;

   // Fetch
   sc_wordmem #(.DEPTH(IMEM_DEPTH), .WIDTH(XLEN), .WRITABLE(1'b0)) u_imem (
      .clk   (clk),
      .re    (1'b1),
      .we    (1'b0),
      .idx   (pc[IAW+1:2]),
      .wdata ('0),
      .rdata (inst)
   );

   // Decode
   sc_decode u_dec (
      .opcode (inst[31:26]),
      .funct  (inst[5:0]),
      .ctrl   (ctrl)
   );

   assign unused_shamt = ^inst[10:6];
   assign rd_addr[0]   = inst[25:21];
   assign rd_addr[1]   = inst[20:16];
   assign waddr        = ctrl.dst_is_rd ? inst[15:11] : inst[20:16];
   assign imm_sx       = {{(XLEN-16){inst[15]}}, inst[15:0]};
   assign reg_we_eff   = ctrl.reg_we && !rst && (waddr != '0);
   assign mem_we_eff   = ctrl.mem_we && !rst;

   sc_regfile #(.NREG(NREG), .WIDTH(XLEN), .NRD(2)) u_rf (
      .clk   (clk),
      .we    (reg_we_eff),
      .waddr (waddr),
      .wdata (wb_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   // Execute
   assign alu_b = ctrl.b_is_imm ? imm_sx : rd_data[1];

   sc_alu #(.WIDTH(XLEN)) u_alu (
      .op   (ctrl.alu_op),
      .a    (rd_data[0]),
      .b    (alu_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // Memory
   sc_wordmem #(.DEPTH(DMEM_DEPTH), .WIDTH(XLEN), .WRITABLE(1'b1)) u_dmem (
      .clk   (clk),
      .re    (ctrl.mem_re),
      .we    (mem_we_eff),
      .idx   (alu_y[DAW+1:2]),
      .wdata (rd_data[1]),
      .rdata (load_data)
   );

   // Write-back
   assign wb_data = ctrl.load_sel ? load_data : alu_y;

   // Next PC
   assign pc_plus4   = pc + 32'd4;
   assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
   assign jmp_target = {pc_plus4[31:28], inst[25:0], 2'b00};
   assign taken      = ctrl.branch && (alu_zero ^ ctrl.branch_ne);

   always_comb begin
      if (ctrl.jump)  next_pc = jmp_target;
      else if (taken) next_pc = br_target;
      else            next_pc = pc_plus4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_PC;
      else     pc <= next_pc;
   end

   // Commit view
   assign pc_o       = pc;
   assign rf_we_o    = reg_we_eff;
   assign rf_waddr_o = waddr;
   assign rf_wdata_o = wb_data;
   assign dm_we_o    = mem_we_eff;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = rd_data[1];

endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk
   import sc_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic [31:0] inst,
   input logic        rf_we,
   input logic [4:0]  rf_waddr,
   input logic        dm_we
);

   logic [5:0]  op;
   logic [31:0] seq_pc, jtgt;
   logic        is_flow, is_br;

   assign op      = inst[31:26];
   assign seq_pc  = pc + 32'd4;
   assign jtgt    = {seq_pc[31:28], inst[25:0], 2'b00};
   assign is_br   = (op == OP_BEQ) || (op == OP_BNE);
   assign is_flow = is_br || (op == OP_J);

   // R1: reset drives the PC to zero and blocks all writes
   a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == 32'h0);
   a_r1_no_write_in_reset: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we));

   // R2: sequential flow advances by one word
   a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
      !is_flow |=> pc == $past(seq_pc));

   // R2: PC stays word aligned
   a_r2_pc_aligned: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00);

   // R5: register 0 is never reported as written
   a_r5_no_zero_write: assert property (@(posedge clk) disable iff (rst)
      rf_we |-> rf_waddr != 5'd0);

   // R6: a store never writes a register in the same cycle
   a_r6_store_excl: assert property (@(posedge clk) disable iff (rst)
      dm_we |-> !rf_we);

   // R7: branches write nothing
   a_r7_branch_quiet: assert property (@(posedge clk) disable iff (rst)
      is_br |-> (!rf_we && !dm_we));

   // R8: jump lands on the region-relative target
   a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
      (op == OP_J) |=> pc == $past(jtgt));

endmodule

bind sc_core sc_core_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc       (pc_o),
   .inst     (inst),
   .rf_we    (rf_we_o),
   .rf_waddr (rf_waddr_o),
   .dm_we    (dm_we_o)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

   localparam int NROW = 25;

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] inst;
      logic        we;
      logic [4:0]  wa;
      logic [31:0] wd;
      logic        se;
      logic [31:0] sa;
      logic [31:0] sd;
      logic [3:0]  req;
   } vec_t;

   function automatic logic [31:0] fr(input logic [5:0] fn, input logic [4:0] rd,
                                      input logic [4:0] rs, input logic [4:0] rt);
      return {6'h00, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] fi(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [4:0] rs, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] fj(input logic [25:0] tgt);
      return {6'h02, tgt};
   endfunction

   function automatic vec_t mk(input logic [31:0] pc, input logic [31:0] inst,
                               input logic we, input logic [4:0] wa, input logic [31:0] wd,
                               input logic se, input logic [31:0] sa, input logic [31:0] sd,
                               input logic [3:0] req);
      vec_t v;
      v.pc = pc; v.inst = inst; v.we = we; v.wa = wa; v.wd = wd;
      v.se = se; v.sa = sa; v.sd = sd; v.req = req;
      return v;
   endfunction

   // Execution order; each row is one retired instruction.
   localparam vec_t TBL [NROW] = '{
      mk(32'd0,   fi(6'h08, 5'd1, 5'd0, 16'd5),      1, 5'd1,  32'd5,        0, 0, 0, 4'd4), // R4
      mk(32'd4,   fi(6'h08, 5'd2, 5'd0, 16'hFFFD),   1, 5'd2,  32'hFFFFFFFD, 0, 0, 0, 4'd4), // R4 negative
      mk(32'd8,   fr(6'h20, 5'd3, 5'd1, 5'd2),       1, 5'd3,  32'd2,        0, 0, 0, 4'd3), // R3 add
      mk(32'd12,  fr(6'h22, 5'd4, 5'd1, 5'd2),       1, 5'd4,  32'd8,        0, 0, 0, 4'd3), // R3 sub
      mk(32'd16,  fr(6'h24, 5'd5, 5'd1, 5'd2),       1, 5'd5,  32'd5,        0, 0, 0, 4'd3), // R3 and
      mk(32'd20,  fr(6'h25, 5'd6, 5'd1, 5'd2),       1, 5'd6,  32'hFFFFFFFD, 0, 0, 0, 4'd3), // R3 or
      mk(32'd24,  fr(6'h26, 5'd7, 5'd1, 5'd2),       1, 5'd7,  32'hFFFFFFF8, 0, 0, 0, 4'd3), // R3 xor
      mk(32'd28,  fr(6'h27, 5'd8, 5'd1, 5'd2),       1, 5'd8,  32'd2,        0, 0, 0, 4'd3), // R3 nor
      mk(32'd32,  fr(6'h2A, 5'd9, 5'd2, 5'd1),       1, 5'd9,  32'd1,        0, 0, 0, 4'd3), // R3 slt true
      mk(32'd36,  fr(6'h2A, 5'd10, 5'd1, 5'd2),      1, 5'd10, 32'd0,        0, 0, 0, 4'd3), // R3 slt false
      mk(32'd40,  fi(6'h08, 5'd0, 5'd1, 16'd7),      0, 5'd0,  32'd0,        0, 0, 0, 4'd5), // R5 write x0
      mk(32'd44,  fr(6'h20, 5'd11, 5'd0, 5'd1),      1, 5'd11, 32'd5,        0, 0, 0, 4'd5), // R5 read x0
      mk(32'd48,  fi(6'h2B, 5'd4, 5'd1, 16'd7),      0, 5'd0,  32'd0,        1, 32'd12, 32'd8, 4'd6), // R6 sw
      mk(32'd52,  fi(6'h23, 5'd12, 5'd1, 16'd7),     1, 5'd12, 32'd8,        0, 0, 0, 4'd6), // R6 lw
      mk(32'd56,  fi(6'h2B, 5'd7, 5'd1, 16'hFFFB),   0, 5'd0,  32'd0,        1, 32'd0, 32'hFFFFFFF8, 4'd6), // R6 neg offset
      mk(32'd60,  fi(6'h23, 5'd13, 5'd0, 16'd0),     1, 5'd13, 32'hFFFFFFF8, 0, 0, 0, 4'd6), // R6 lw
      mk(32'd64,  fi(6'h04, 5'd11, 5'd1, 16'd2),     0, 5'd0,  32'd0,        0, 0, 0, 4'd7), // R7 beq taken
      mk(32'd76,  fi(6'h05, 5'd11, 5'd1, 16'd5),     0, 5'd0,  32'd0,        0, 0, 0, 4'd7), // R7 bne not taken
      mk(32'd80,  fi(6'h05, 5'd2, 5'd1, 16'd1),      0, 5'd0,  32'd0,        0, 0, 0, 4'd7), // R7 bne taken
      mk(32'd88,  fi(6'h04, 5'd2, 5'd1, 16'd3),      0, 5'd0,  32'd0,        0, 0, 0, 4'd7), // R7 beq not taken
      mk(32'd92,  fj(26'd30),                        0, 5'd0,  32'd0,        0, 0, 0, 4'd8), // R8 jump
      mk(32'd120, {6'h3F, 5'd1, 5'd15, 16'h0010},    0, 5'd0,  32'd0,        0, 0, 0, 4'd9), // R9 bad opcode
      mk(32'd124, fr(6'h3F, 5'd16, 5'd1, 5'd2),      0, 5'd0,  32'd0,        0, 0, 0, 4'd9), // R9 bad funct
      mk(32'd128, fi(6'h04, 5'd0, 5'd0, 16'hFFFF),   0, 5'd0,  32'd0,        0, 0, 0, 4'd7), // R7 backward
      mk(32'd128, fi(6'h04, 5'd0, 5'd0, 16'hFFFF),   0, 5'd0,  32'd0,        0, 0, 0, 4'd2)  // R2 one per edge
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic [4:0]  rf_waddr_o;
   logic        rf_we_o, dm_we_o;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;

   always #2 clk = ~clk;

   sc_core u_dut (
      .clk        (clk),
      .rst        (rst),
      .pc_o       (pc_o),
      .rf_we_o    (rf_we_o),
      .rf_waddr_o (rf_waddr_o),
      .rf_wdata_o (rf_wdata_o),
      .dm_we_o    (dm_we_o),
      .dm_addr_o  (dm_addr_o),
      .dm_wdata_o (dm_wdata_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_row(input vec_t v);
      string t;
      t = $sformatf("R%0d pc=%0d", v.req, v.pc);
      check({t, " pc (R2)"}, pc_o, v.pc);
      check({t, " reg write enable"}, {31'd0, rf_we_o}, {31'd0, v.we});
      if (v.we) begin
         check({t, " reg dest"}, {27'd0, rf_waddr_o}, {27'd0, v.wa});
         check({t, " reg data"}, rf_wdata_o, v.wd);
      end
      check({t, " store enable"}, {31'd0, dm_we_o}, {31'd0, v.se});
      if (v.se) begin
         check({t, " store addr"}, dm_addr_o, v.sa);
         check({t, " store data"}, dm_wdata_o, v.sd);
      end
   endtask

   initial begin
      // Filler in every word: add-immediate to r14, must never retire.
      for (int w = 0; w < 256; w++) u_dut.u_imem.cells[w] = fi(6'h08, 5'd14, 5'd0, 16'd99);
      for (int i = 0; i < NROW; i++) u_dut.u_imem.cells[TBL[i].pc[9:2]] = TBL[i].inst;

      @(posedge clk);
      @(negedge clk);
      // R1: in reset the PC is 0 and the fetched add-immediate is not committed
      check("R1 pc in reset", pc_o, 32'd0);
      check("R1 no reg write in reset", {31'd0, rf_we_o}, 32'd0);
      check("R1 no store in reset", {31'd0, dm_we_o}, 32'd0);
      rst = 1'b0;
      #1;
      for (int i = 0; i < NROW; i++) begin
         if (i > 0) begin
            @(negedge clk);
            #1;
         end
         check_row(TBL[i]);
      end
      @(negedge clk);
      #1;
      check("R7 self-loop holds pc", pc_o, 32'd128);

      // R1: reset in the middle of a run
      rst = 1'b1;
      @(negedge clk);
      #1;
      check("R1 mid-run reset pc", pc_o, 32'd0);
      check("R1 mid-run reset blocks write", {31'd0, rf_we_o}, 32'd0);
      rst = 1'b0;
      #1;
      check_row(TBL[0]);
      @(negedge clk);
      #1;
      check_row(TBL[1]);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule